// File: doc/BRIEF.md
# Request-gated word FIFO feeding a DMA channel

A host CPU writes 16-bit words through a data port, and this bridge buffers them in a small FIFO. A DMA channel on a second bus then drains the FIFO and emits each word as a 16-bit write on a simple write-master port. The host can load the FIFO only after it has set the request-enable bit in the control register. Draining happens in bursts. A burst begins only when the FIFO holds a nonzero multiple of four words and the channel is armed. The channel is armed when its mode field is `2'b01` and the global DMA enable is high.

Before each transfer, the channel side loads a destination address and a transfer count through a start strobe. Each emitted word raises the destination by 2 and lowers the count by 1. When the count reaches zero, the bridge drops request-enable and raises a transfer-end flag. The FIFO is emptied at the end of every burst.

The engine has three states. `ST_IDLE` is left for `ST_DRAIN` on the transition *burst-ready*. `ST_DRAIN` emits one word per cycle and takes the transition *drain-done* to `ST_FINISH` after its last word, or when it has nothing to emit. `ST_FINISH` clears the FIFO, updates the end status, and returns to `ST_IDLE` on the transition *wrap-up*.

Top module: `dreq_dma_bridge`

## Requirements
- R1: After reset, the control read is 0x0000, the length read is 0x0000, `dma_wr_valid` is 0, `ch_end` is 0 and `ch_count` is 0.
- R2: A host write to the FIFO port (`host_addr`=2) is dropped unless control bit 0 (request-enable) is set.
- R3: Accepted words fill the FIFO in order. When it holds DEPTH (8) words, control bit 7 (FULL) reads 1, and further FIFO writes are dropped.
- R4: A burst starts only when the buffered count is a nonzero multiple of 4, `ch_mode` is 2'b01 and `dma_global_en` is 1. Arming the channel while 4 or 8 words wait starts a burst at once.
- R5: A burst emits the buffered words oldest first, one per cycle. It places the first at the loaded destination, raises the address by 2 per word, and lowers `ch_count` by 1 per word. The first word is valid in the cycle after the edge that stored the fourth word.
- R6: A burst stops early once `ch_count` reaches zero. No word is emitted while the count is zero.
- R7: After a burst, the FIFO is empty and FULL reads 0. The next words written start a fresh fill.
- R8: When a burst ends with the count at zero, control bit 0 is cleared and `ch_end` is set. `ch_start` clears `ch_end`.
- R9: Host writes to control (`host_addr`=0) change only bits 0 (request-enable), 1 (DMA) and 2 (RV). Bit 7 stays hardware FULL status.
- R10: `ch_start`, taken while idle, loads the destination and the count masked to its low 24 bits.
- R11: FIFO writes that arrive while a burst is in progress are dropped.
- R12: The length register (`host_addr`=1) stores and reads back a 16-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 2 | Register select: 0 control, 1 length, 2 FIFO port |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data for `host_addr` (combinational) |
| ch_start | input | 1 | Load destination and count (accepted when idle) |
| ch_dst_in | input | 32 | Destination address to load |
| ch_count_in | input | 32 | Transfer count to load (low 24 bits kept) |
| ch_mode | input | 2 | Channel mode; 2'b01 arms request-driven draining |
| dma_global_en | input | 1 | Global DMA enable |
| dma_wr_valid | output | 1 | A word write is presented this cycle |
| dma_wr_addr | output | 32 | Write destination address |
| dma_wr_data | output | 16 | Write data word |
| ch_count | output | 24 | Remaining transfer count |
| ch_end | output | 1 | Transfer-end status |

## Verification
A FIFO or register write shows in the host read after the edge that samples it. The fourth word arms `burst-ready` at the next edge. The first DMA word is therefore valid one full cycle after the write edge, and the remaining words follow one per cycle. The end status, the cleared request bit and the cleared FULL flag appear two edges after the last word. The bench drives inputs and samples outputs on falling edges. It checks the valid line at the exact falling edges around the fourth write, and logs every DMA word at falling edges. Status reads are made only after an idle gap longer than the longest burst.

// File: rtl/dreq_pkg.sv
package dreq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_FINISH = 2'd2
    } drain_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_LEN  = 2'd1;
    localparam logic [1:0] SEL_FIFO = 2'd2;

    localparam int BIT_REQ  = 0;
    localparam int BIT_DMA  = 1;
    localparam int BIT_RV   = 2;
    localparam int BIT_FULL = 7;

    localparam logic [1:0] MODE_REQ_DRIVEN = 2'b01;
endpackage

// File: rtl/dreq_host_regs.sv
module dreq_host_regs
    import dreq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              req_clr,
    input  logic              fifo_full,
    output logic [DATA_W-1:0] host_rdata,
    output logic              req_en,
    output logic              fifo_wr_req
);
    logic dma_bit;
    logic rv_bit;
    logic [DATA_W-1:0] len_q;
    logic ctrl_wr;

    assign ctrl_wr     = host_we && (host_addr == SEL_CTRL);
    assign fifo_wr_req = host_we && (host_addr == SEL_FIFO) && req_en;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_en  <= 1'b0;
            dma_bit <= 1'b0;
            rv_bit  <= 1'b0;
            len_q   <= '0;
        end else begin
            if (ctrl_wr) begin
                req_en  <= host_wdata[BIT_REQ];
                dma_bit <= host_wdata[BIT_DMA];
                rv_bit  <= host_wdata[BIT_RV];
            end
            if (req_clr) begin
                req_en <= 1'b0;
            end
            if (host_we && (host_addr == SEL_LEN)) begin
                len_q <= host_wdata;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            SEL_CTRL: begin
                host_rdata[BIT_REQ]  = req_en;
                host_rdata[BIT_DMA]  = dma_bit;
                host_rdata[BIT_RV]   = rv_bit;
                host_rdata[BIT_FULL] = fifo_full;
            end
            SEL_LEN:  host_rdata = len_q;
            default:  host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dreq_fifo.sv
module dreq_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH + 1),
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              block,
    input  logic              clear,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  level,
    output logic              full
);
    localparam logic [PTR_W-1:0] LEVEL_MAX = PTR_W'(DEPTH);

    logic [DATA_W-1:0] entry [DEPTH];
    logic push;

    assign push = wr_req && !block && !full;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry[g] <= '0;
            end else if (push && (level[IDX_W-1:0] == IDX_W'(g))) begin
                entry[g] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            full  <= 1'b0;
        end else if (clear) begin
            level <= '0;
            full  <= 1'b0;
        end else if (push) begin
            level <= level + PTR_W'(1);
            full  <= (level + PTR_W'(1)) == LEVEL_MAX;
        end
    end

    assign rd_data = entry[rd_idx];
endmodule

// File: rtl/dreq_drain_fsm.sv
module dreq_drain_fsm
    import dreq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 32,
    parameter int CFG_W   = 32,
    parameter int COUNT_W = 24,
    parameter int PTR_W   = 4,
    parameter int IDX_W   = 3,
    parameter int BURST   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ch_start,
    input  logic [ADDR_W-1:0]  ch_dst_in,
    input  logic [CFG_W-1:0]   ch_count_in,
    input  logic [1:0]         ch_mode,
    input  logic               dma_global_en,
    input  logic [PTR_W-1:0]   level,
    input  logic [DATA_W-1:0]  rd_data,
    output logic [IDX_W-1:0]   rd_idx,
    output logic               busy,
    output logic               fifo_clear,
    output logic               req_clr,
    output logic               wr_valid,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [COUNT_W-1:0] ch_count,
    output logic               ch_end
);
    localparam logic [PTR_W-1:0] BURST_MASK = PTR_W'(BURST - 1);
    localparam logic [CFG_W-1:0] CNT_MASK   = CFG_W'((64'd1 << COUNT_W) - 64'd1);

    drain_state_e state, state_nx;
    logic [PTR_W-1:0]  idx;
    logic [ADDR_W-1:0] dst;
    logic              burst_ready;
    logic              more;
    logic              last_word;
    logic              cnt_zero;

    assign cnt_zero    = (ch_count == '0);
    assign burst_ready = (level != '0) && ((level & BURST_MASK) == '0)
                         && (ch_mode == MODE_REQ_DRIVEN) && dma_global_en
                         && !ch_start;
    assign more        = (idx < level) && !cnt_zero;
    assign last_word   = ((idx + PTR_W'(1)) == level) || (ch_count == COUNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: burst-ready, drain-done, wrap-up
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (burst_ready) state_nx = ST_DRAIN;
            ST_DRAIN:  if (!more || last_word) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_valid   = 1'b0;
        fifo_clear = 1'b0;
        req_clr    = 1'b0;
        busy       = 1'b1;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_DRAIN:  wr_valid = more;
            ST_FINISH: begin
                fifo_clear = 1'b1;
                req_clr    = cnt_zero;
            end
            default:   busy = 1'b0;
        endcase
    end

    assign rd_idx  = idx[IDX_W-1:0];
    assign wr_addr = dst;
    assign wr_data = rd_data;

    // channel datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            dst      <= '0;
            ch_count <= '0;
            ch_end   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    idx <= '0;
                    if (ch_start) begin
                        dst      <= ch_dst_in;
                        ch_count <= COUNT_W'(ch_count_in & CNT_MASK);
                        ch_end   <= 1'b0;
                    end
                end
                ST_DRAIN: begin
                    if (more) begin
                        idx      <= idx + PTR_W'(1);
                        dst      <= dst + ADDR_W'(2);
                        ch_count <= ch_count - COUNT_W'(1);
                    end
                end
                ST_FINISH: begin
                    idx <= '0;
                    if (cnt_zero) ch_end <= 1'b1;
                end
                default: idx <= '0;
            endcase
        end
    end
endmodule

// File: rtl/dreq_dma_bridge.sv
module dreq_dma_bridge #(
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = 32,
    parameter int CFG_W   = 32,
    parameter int COUNT_W = 24,
    parameter int DEPTH   = 8,
    parameter int BURST   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [1:0]         host_addr,
    input  logic [DATA_W-1:0]  host_wdata,
    output logic [DATA_W-1:0]  host_rdata,
    input  logic               ch_start,
    input  logic [ADDR_W-1:0]  ch_dst_in,
    input  logic [CFG_W-1:0]   ch_count_in,
    input  logic [1:0]         ch_mode,
    input  logic               dma_global_en,
    output logic               dma_wr_valid,
    output logic [ADDR_W-1:0]  dma_wr_addr,
    output logic [DATA_W-1:0]  dma_wr_data,
    output logic [COUNT_W-1:0] ch_count,
    output logic               ch_end
);
    localparam int PTR_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              req_en;
    logic              req_clr;
    logic              fifo_wr_req;
    logic              fifo_full;
    logic              fifo_clear;
    logic              drain_busy;
    logic [PTR_W-1:0]  fifo_level;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;

    dreq_host_regs #(.DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .req_clr    (req_clr),
        .fifo_full  (fifo_full),
        .host_rdata (host_rdata),
        .req_en     (req_en),
        .fifo_wr_req(fifo_wr_req)
    );

    dreq_fifo #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .IDX_W(IDX_W)
    ) u_fifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_req (fifo_wr_req),
        .wr_data(host_wdata),
        .block  (drain_busy),
        .clear  (fifo_clear),
        .rd_idx (rd_idx),
        .rd_data(rd_data),
        .level  (fifo_level),
        .full   (fifo_full)
    );

    dreq_drain_fsm #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CFG_W(CFG_W), .COUNT_W(COUNT_W),
        .PTR_W(PTR_W), .IDX_W(IDX_W), .BURST(BURST)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_start     (ch_start),
        .ch_dst_in    (ch_dst_in),
        .ch_count_in  (ch_count_in),
        .ch_mode      (ch_mode),
        .dma_global_en(dma_global_en),
        .level        (fifo_level),
        .rd_data      (rd_data),
        .rd_idx       (rd_idx),
        .busy         (drain_busy),
        .fifo_clear   (fifo_clear),
        .req_clr      (req_clr),
        .wr_valid     (dma_wr_valid),
        .wr_addr      (dma_wr_addr),
        .wr_data      (dma_wr_data),
        .ch_count     (ch_count),
        .ch_end       (ch_end)
    );
endmodule

// File: rtl/dreq_dma_bridge_chk.sv
module dreq_dma_bridge_chk #(
    parameter int ADDR_W  = 32,
    parameter int COUNT_W = 24,
    parameter int DEPTH   = 8,
    parameter int PTR_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               dma_wr_valid,
    input logic [ADDR_W-1:0]  dma_wr_addr,
    input logic [COUNT_W-1:0] ch_count,
    input logic               ch_end,
    input logic [PTR_W-1:0]   level,
    input logic               full,
    input logic               req_en
);
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level <= PTR_W'(DEPTH));

    p_full_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (level == PTR_W'(DEPTH)));

    p_gate_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level == $past(level) + PTR_W'(1)) |-> $past(req_en));

    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_valid |=> (!dma_wr_valid || (dma_wr_addr == $past(dma_wr_addr) + ADDR_W'(2))));

    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_valid |=> (ch_count == $past(ch_count) - COUNT_W'(1)));

    p_no_word_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_wr_valid |-> (ch_count != '0));

    p_end_drops_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ch_end) |-> !req_en);

    p_clear_after_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dma_wr_valid) |=> (level == '0));
endmodule

bind dreq_dma_bridge dreq_dma_bridge_chk #(
    .ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .DEPTH(DEPTH), .PTR_W(PTR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .dma_wr_valid(dma_wr_valid),
    .dma_wr_addr (dma_wr_addr),
    .ch_count    (ch_count),
    .ch_end      (ch_end),
    .level       (fifo_level),
    .full        (fifo_full),
    .req_en      (req_en)
);

// File: tb/dreq_dma_bridge_tb.sv
`timescale 1ns/1ps
module dreq_dma_bridge_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        ch_start = 1'b0;
    logic [31:0] ch_dst_in = '0;
    logic [31:0] ch_count_in = '0;
    logic [1:0]  ch_mode = 2'b00;
    logic        dma_global_en = 1'b0;
    logic        dma_wr_valid;
    logic [31:0] dma_wr_addr;
    logic [15:0] dma_wr_data;
    logic [23:0] ch_count;
    logic        ch_end;

    int n_checks = 0;
    int n_fail = 0;
    int nlog = 0;
    logic [31:0] log_addr [64];
    logic [15:0] log_data [64];

    always #2.5 clk = ~clk;

    dreq_dma_bridge u_dut (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .ch_start(ch_start),
        .ch_dst_in(ch_dst_in), .ch_count_in(ch_count_in), .ch_mode(ch_mode),
        .dma_global_en(dma_global_en), .dma_wr_valid(dma_wr_valid),
        .dma_wr_addr(dma_wr_addr), .dma_wr_data(dma_wr_data),
        .ch_count(ch_count), .ch_end(ch_end)
    );

    always @(negedge clk) begin
        if (rst_n && dma_wr_valid && nlog < 64) begin
            log_addr[nlog] = dma_wr_addr;
            log_data[nlog] = dma_wr_data;
            nlog = nlog + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic chan_load(input logic [31:0] dst, input logic [31:0] cnt);
        @(negedge clk);
        ch_start = 1'b1; ch_dst_in = dst; ch_count_in = cnt;
        @(negedge clk);
        ch_start = 1'b0;
    endtask

    task automatic settle();
        repeat (14) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        host_rd(2'd0, v);
        check(v == 16'h0000, "R1 ctrl after reset", {16'h0, v}, 32'h0);
        host_rd(2'd1, v);
        check(v == 16'h0000, "R1 length after reset", {16'h0, v}, 32'h0);
        check(!dma_wr_valid && !ch_end && ch_count == 0, "R1 channel idle",
              {7'h0, dma_wr_valid, ch_end, ch_count}, 32'h0);
    endtask

    task automatic t_length();
        logic [15:0] v;
        host_wr(2'd1, 16'h1234);
        host_rd(2'd1, v);
        check(v == 16'h1234, "R12 length readback", {16'h0, v}, 32'h1234);
    endtask

    task automatic t_ctrl_bits();
        logic [15:0] v;
        host_wr(2'd0, 16'hFFFF);
        host_rd(2'd0, v);
        check(v == 16'h0007, "R9 ctrl writable bits only", {16'h0, v}, 32'h7);
        host_wr(2'd0, 16'h0000);
    endtask

    task automatic t_gate_and_order();
        int base;
        host_wr(2'd2, 16'hDEAD);          // request disabled: R2 dropped
        host_wr(2'd0, 16'h0001);
        chan_load(32'h0000_1000, 32'd100);
        ch_mode = 2'b01; dma_global_en = 1'b1;
        base = nlog;
        for (int i = 0; i < 3; i++) host_wr(2'd2, 16'hA000 + 16'(i));
        @(negedge clk);
        check(nlog == base, "R2 gated word not counted (no burst at 3)", nlog - base, 0);
        host_wr(2'd2, 16'hA003);
        // now at falling edge right after the edge storing word 4
        check(dma_wr_valid == 1'b0, "R5 valid low right after 4th write", {31'h0, dma_wr_valid}, 0);
        @(negedge clk);
        check(dma_wr_valid == 1'b1 && dma_wr_data == 16'hA000, "R5 first word one cycle later",
              {15'h0, dma_wr_valid, dma_wr_data}, 32'h1_A000);
        settle();
        check(nlog - base == 4, "R2 R4 burst length", nlog - base, 4);
        for (int i = 0; i < 4; i++) begin
            check(log_data[base+i] == 16'hA000 + 16'(i), "R5 word order",
                  {16'h0, log_data[base+i]}, 32'hA000 + i);
            check(log_addr[base+i] == 32'h1000 + 32'(2*i), "R5 address step",
                  log_addr[base+i], 32'h1000 + 2*i);
        end
        check(ch_count == 24'd96, "R5 count decrement", {8'h0, ch_count}, 96);
    endtask

    task automatic t_not_armed();
        int base;
        ch_mode = 2'b10;
        base = nlog;
        for (int i = 0; i < 4; i++) host_wr(2'd2, 16'hB000 + 16'(i));
        settle();
        check(nlog == base, "R4 no burst with mode 10", nlog - base, 0);
        ch_mode = 2'b01; dma_global_en = 1'b0;
        settle();
        check(nlog == base, "R4 no burst without global enable", nlog - base, 0);
        dma_global_en = 1'b1;
        settle();
        check(nlog - base == 4 && log_data[base] == 16'hB000, "R4 arming starts burst",
              nlog - base, 4);
        check(log_addr[base] == 32'h1008, "R5 destination continues", log_addr[base], 32'h1008);
    endtask

    task automatic t_full();
        logic [15:0] v;
        int base;
        ch_mode = 2'b00;
        for (int i = 0; i < 9; i++) host_wr(2'd2, 16'hC000 + 16'(i));
        host_rd(2'd0, v);
        check(v == 16'h0081, "R3 full flag set", {16'h0, v}, 32'h81);
        host_wr(2'd0, 16'h0000);
        host_rd(2'd0, v);
        check(v == 16'h0080, "R9 full kept on ctrl write", {16'h0, v}, 32'h80);
        host_wr(2'd0, 16'h0001);
        base = nlog;
        ch_mode = 2'b01;
        settle();
        check(nlog - base == 8, "R3 eight words drained", nlog - base, 8);
        check(log_data[base+7] == 16'hC007, "R3 ninth word dropped", {16'h0, log_data[base+7]}, 32'hC007);
        host_rd(2'd0, v);
        check(v == 16'h0001, "R7 full cleared after burst", {16'h0, v}, 32'h1);
    endtask

    task automatic t_early_stop();
        logic [15:0] v;
        int base;
        chan_load(32'h0000_2000, 32'd3);
        check(ch_end == 1'b0, "R8 start clears end", {31'h0, ch_end}, 0);
        base = nlog;
        for (int i = 0; i < 4; i++) host_wr(2'd2, 16'hD000 + 16'(i));
        settle();
        check(nlog - base == 3, "R6 stops at zero count", nlog - base, 3);
        check(ch_count == 0 && ch_end == 1'b1, "R8 end flag set", {7'h0, ch_end, ch_count}, 32'h0100_0000);
        host_rd(2'd0, v);
        check(v[0] == 1'b0, "R8 request cleared", {16'h0, v}, 32'h0);
        host_wr(2'd0, 16'h0001);
        chan_load(32'h0000_3000, 32'd8);
        base = nlog;
        for (int i = 0; i < 4; i++) host_wr(2'd2, 16'hE000 + 16'(i));
        settle();
        check(nlog - base == 4 && log_data[base] == 16'hE000, "R7 fresh fill after burst",
              {16'h0, log_data[base]}, 32'hE000);
    endtask

    task automatic t_busy_drop();
        int base;
        chan_load(32'h0000_4000, 32'd50);
        base = nlog;
        for (int i = 0; i < 4; i++) host_wr(2'd2, 16'h5000 + 16'(i));
        host_wr(2'd2, 16'h5999);          // lands during the burst: R11 dropped
        settle();
        check(nlog - base == 4, "R11 burst unchanged", nlog - base, 4);
        base = nlog;
        for (int i = 0; i < 4; i++) host_wr(2'd2, 16'h6000 + 16'(i));
        settle();
        check(nlog - base == 4 && log_data[base] == 16'h6000, "R11 busy write dropped",
              {16'h0, log_data[base]}, 32'h6000);
    endtask

    task automatic t_mask();
        chan_load(32'h0000_5000, 32'h0100_0005);
        check(ch_count == 24'd5, "R10 count masked to 24 bits", {8'h0, ch_count}, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_length();
        t_ctrl_bits();
        t_gate_and_order();
        t_not_armed();
        t_full();
        t_early_stop();
        t_busy_drop();
        t_mask();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule